// File: doc/BRIEF.md
# Single-Pass Connected-Component Blob Labeler

This block labels connected foreground regions in a raster image while the image streams past, one pixel per clock. Each incoming intensity is compared against a threshold to yield a foreground flag. A foreground pixel is labelled from its west neighbour (the previous pixel on the same line) and its north neighbour (the pixel one line above, held in a one-line label buffer). When the two neighbours carry different labels, the regions are joined on the spot. The higher-numbered label is redirected to the lower one, and the statistics gathered under the higher label are added into the lower label's entry.

For every label, the block keeps a running pixel count and the sums of the column and row indices. Once the last pixel of a frame has gone in, a host selects a label on `rd_label` and reads whether the label is still a live region, together with its area and both coordinate sums. Dividing each sum by the area gives the centroid. That division is done outside the block. No second scan of the image is needed.

Top module: `blob_labeler`

## Requirements
- R1: A pixel presented with `pix_valid` high is foreground when `pix_data >= threshold` (unsigned). Otherwise it is background and changes no statistics.
- R2: A foreground pixel with no foreground west or north neighbour receives a fresh label. Labels are issued from a counter that restarts at 0 on the `sof` pixel and increments once per issued label. In row 0 the north neighbour counts as background, and in column 0 the west neighbour counts as background.
- R3: A foreground pixel whose only foreground neighbour is west joins the west neighbour's region.
- R4: A foreground pixel whose only foreground neighbour is north joins the north neighbour's region. The north label comes from the previous line at the same column. All lines of a frame carry the same number of pixels, at most `COLS`.
- R5: When both neighbours are foreground and belong to the same region, the pixel joins that region and no merge takes place.
- R6: When both neighbours belong to different regions, the lower label survives. The higher label's area and sums are added into the survivor, and the higher label stops being live. Any later reference to the higher label, including from the line buffer, resolves to the survivor.
- R7: The pixel that triggers a merge adds exactly one to the survivor's area, plus its own column and row once.
- R8: If a fresh label is needed after all `NLABELS` labels have been issued in the frame, `label_overflow` goes high on the next clock. That pixel is treated as background. The flag stays high until the next `sof` pixel.
- R9: For label `rd_label`, the readout shows `rd_live`, `rd_area`, `rd_sumx` (sum of column indices, counted from 0 at each line start) and `rd_sumy` (sum of row indices, counted from 0 at `sof`). The readout reflects all pixels accepted up to the last clock edge.
- R10: After reset no label is live and both flags are low. A `sof` pixel discards all earlier statistics and clears `label_overflow`. `frame_done` goes high on the clock after the `eof` pixel and goes low on the clock after the next `sof` pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | A pixel is presented this cycle |
| sof | input | 1 | Marks the first pixel of a frame |
| eol | input | 1 | Marks the last pixel of a line |
| eof | input | 1 | Marks the last pixel of a frame |
| pix_data | input | DATA_W | Pixel intensity |
| threshold | input | DATA_W | Foreground threshold |
| rd_label | input | LABEL_W | Label selected for readout |
| rd_live | output | 1 | Selected label is a live region |
| rd_area | output | AREA_W | Pixel count of the selected label |
| rd_sumx | output | SX_W | Sum of column indices of the selected label |
| rd_sumy | output | SY_W | Sum of row indices of the selected label |
| label_overflow | output | 1 | A fresh label was needed with none left |
| frame_done | output | 1 | The last pixel of the frame has been taken |

## Verification
Folding a merged region's statistics and adding the current pixel both happen in the same cycle, on the same surviving entry. U-shaped regions whose arms meet on a later line force this coincidence, as do dense random frames. The survivor's area and sums must then equal the combined totals plus exactly one pixel. A behavioural union-find model with parent pointers runs in the bench. Every clock, its per-label totals, its flags and its live set are compared against the readout port, which sweeps through all labels.

// File: rtl/blob_pkg.sv
package blob_pkg;

    // What the labeling decision does with the current pixel
    typedef enum logic [1:0] {
        ACT_IDLE  = 2'd0,   // background, or dropped for lack of labels
        ACT_FRESH = 2'd1,   // open a new region
        ACT_JOIN  = 2'd2,   // extend one existing region
        ACT_MERGE = 2'd3    // extend and join two regions
    } blob_act_e;

    function automatic int blob_sum_width(input int cols, input int rows, input int span);
        return $clog2(cols * rows * span);
    endfunction

endpackage

// File: rtl/blob_linebuf.sv
module blob_linebuf #(
    parameter int COLS    = 16,
    parameter int LABEL_W = 4,
    parameter int COL_W   = $clog2(COLS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [COL_W-1:0]   col,
    input  logic               wr_fg,
    input  logic [LABEL_W-1:0] wr_lab,
    output logic               rd_fg,
    output logic [LABEL_W-1:0] rd_lab
);
    logic               fg_q  [COLS];
    logic [LABEL_W-1:0] lab_q [COLS];

    // Read-before-write: the slot still holds the previous line's entry
    assign rd_fg  = fg_q[col];
    assign rd_lab = lab_q[col];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < COLS; i++) begin
                fg_q[i]  <= 1'b0;
                lab_q[i] <= '0;
            end
        end else if (wr_en) begin
            fg_q[col]  <= wr_fg;
            lab_q[col] <= wr_lab;
        end
    end
endmodule

// File: rtl/blob_decide.sv
module blob_decide
    import blob_pkg::*;
#(
    parameter int NLABELS = 16,
    parameter int LABEL_W = $clog2(NLABELS),
    parameter int CNT_W   = LABEL_W + 1
) (
    input  logic               fg,
    input  logic               n_fg,
    input  logic [LABEL_W-1:0] n_root,
    input  logic               w_fg,
    input  logic [LABEL_W-1:0] w_root,
    input  logic [CNT_W-1:0]   free_cnt,
    output blob_act_e          act,
    output logic [LABEL_W-1:0] lab,
    output logic [LABEL_W-1:0] gone,
    output logic               starve
);
    always_comb begin
        act    = ACT_IDLE;
        lab    = '0;
        gone   = '0;
        starve = 1'b0;
        if (fg) begin
            unique case ({w_fg, n_fg})
                2'b10: begin
                    act = ACT_JOIN;
                    lab = w_root;
                end
                2'b01: begin
                    act = ACT_JOIN;
                    lab = n_root;
                end
                2'b11: begin
                    if (n_root == w_root) begin
                        act = ACT_JOIN;
                        lab = n_root;
                    end else begin
                        act  = ACT_MERGE;
                        lab  = (n_root < w_root) ? n_root : w_root;
                        gone = (n_root < w_root) ? w_root : n_root;
                    end
                end
                default: begin
                    if (free_cnt == CNT_W'(NLABELS)) begin
                        starve = 1'b1;
                    end else begin
                        act = ACT_FRESH;
                        lab = free_cnt[LABEL_W-1:0];
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/blob_table.sv
module blob_table
    import blob_pkg::*;
#(
    parameter int NLABELS = 16,
    parameter int LABEL_W = $clog2(NLABELS),
    parameter int COL_W   = 4,
    parameter int ROW_W   = 4,
    parameter int AREA_W  = 9,
    parameter int SX_W    = 12,
    parameter int SY_W    = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  blob_act_e          act,
    input  logic [LABEL_W-1:0] lab,
    input  logic [LABEL_W-1:0] gone,
    input  logic [COL_W-1:0]   col,
    input  logic [ROW_W-1:0]   row,
    input  logic [LABEL_W-1:0] n_raw,
    input  logic [LABEL_W-1:0] w_raw,
    output logic [LABEL_W-1:0] n_root,
    output logic [LABEL_W-1:0] w_root,
    input  logic [LABEL_W-1:0] rd_label,
    output logic               rd_live,
    output logic [AREA_W-1:0]  rd_area,
    output logic [SX_W-1:0]    rd_sumx,
    output logic [SY_W-1:0]    rd_sumy
);
    // Every entry points straight at its region's surviving label
    logic [LABEL_W-1:0] root_q [NLABELS];
    logic               live_q [NLABELS];
    logic [AREA_W-1:0]  area_q [NLABELS];
    logic [SX_W-1:0]    sx_q   [NLABELS];
    logic [SY_W-1:0]    sy_q   [NLABELS];

    logic [SX_W-1:0]   px;
    logic [SY_W-1:0]   py;
    logic [AREA_W-1:0] join_area, merge_area;
    logic [SX_W-1:0]   join_sx, merge_sx;
    logic [SY_W-1:0]   join_sy, merge_sy;

    assign n_root = root_q[n_raw];
    assign w_root = root_q[w_raw];

    assign rd_live = live_q[rd_label];
    assign rd_area = area_q[rd_label];
    assign rd_sumx = sx_q[rd_label];
    assign rd_sumy = sy_q[rd_label];

    assign px = SX_W'(col);
    assign py = SY_W'(row);

    always_comb begin
        join_area  = area_q[lab] + AREA_W'(1);
        join_sx    = sx_q[lab] + px;
        join_sy    = sy_q[lab] + py;
        merge_area = join_area + area_q[gone];
        merge_sx   = join_sx + sx_q[gone];
        merge_sy   = join_sy + sy_q[gone];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NLABELS; i++) begin
                root_q[i] <= LABEL_W'(i);
                live_q[i] <= 1'b0;
                area_q[i] <= '0;
                sx_q[i]   <= '0;
                sy_q[i]   <= '0;
            end
        end else begin
            if (clear) begin
                for (int i = 0; i < NLABELS; i++) begin
                    live_q[i] <= 1'b0;
                    area_q[i] <= '0;
                    sx_q[i]   <= '0;
                    sy_q[i]   <= '0;
                end
            end
            unique case (act)
                ACT_FRESH: begin
                    root_q[lab] <= lab;
                    live_q[lab] <= 1'b1;
                    area_q[lab] <= AREA_W'(1);
                    sx_q[lab]   <= px;
                    sy_q[lab]   <= py;
                end
                ACT_JOIN: begin
                    area_q[lab] <= join_area;
                    sx_q[lab]   <= join_sx;
                    sy_q[lab]   <= join_sy;
                end
                ACT_MERGE: begin
                    for (int i = 0; i < NLABELS; i++) begin
                        if (root_q[i] == gone) root_q[i] <= lab;
                    end
                    area_q[lab]  <= merge_area;
                    sx_q[lab]    <= merge_sx;
                    sy_q[lab]    <= merge_sy;
                    live_q[gone] <= 1'b0;
                    area_q[gone] <= '0;
                    sx_q[gone]   <= '0;
                    sy_q[gone]   <= '0;
                end
                default: ;
            endcase
        end
    end

    // R6: the survivor is always the lower label
    a_r6_keep_lower: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_MERGE) |-> (lab < gone));

    // R6: the absorbed label is no longer live after the merge
    a_r6_gone_dead: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_MERGE) |=> !live_q[$past(gone)]);

    // R3: a pixel only ever joins a region that is live
    a_r3_join_live: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_JOIN) |-> live_q[lab]);

    // R7: a merge grows the survivor by the absorbed area plus one pixel
    a_r7_single_count: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_MERGE) |=>
        (area_q[$past(lab)] == $past(area_q[lab]) + $past(area_q[gone]) + AREA_W'(1)));
endmodule

// File: rtl/blob_labeler.sv
module blob_labeler
    import blob_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int COLS    = 16,
    parameter int ROWS    = 16,
    parameter int NLABELS = 16,
    parameter int LABEL_W = $clog2(NLABELS),
    parameter int AREA_W  = $clog2(COLS * ROWS + 1),
    parameter int SX_W    = blob_sum_width(COLS, ROWS, COLS),
    parameter int SY_W    = blob_sum_width(COLS, ROWS, ROWS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pix_valid,
    input  logic               sof,
    input  logic               eol,
    input  logic               eof,
    input  logic [DATA_W-1:0]  pix_data,
    input  logic [DATA_W-1:0]  threshold,
    input  logic [LABEL_W-1:0] rd_label,
    output logic               rd_live,
    output logic [AREA_W-1:0]  rd_area,
    output logic [SX_W-1:0]    rd_sumx,
    output logic [SY_W-1:0]    rd_sumy,
    output logic               label_overflow,
    output logic               frame_done
);
    localparam int COL_W = $clog2(COLS);
    localparam int ROW_W = $clog2(ROWS);
    localparam int CNT_W = LABEL_W + 1;

    logic [COL_W-1:0]   col_q, col;
    logic [ROW_W-1:0]   row_q, row;
    logic [CNT_W-1:0]   free_q, free_cnt;
    logic               wfg_q;
    logic [LABEL_W-1:0] wlab_q;
    logic               ovf_q, done_q;
    logic               start;

    logic               fg, n_fg, w_fg, lb_fg, starve, hit;
    logic [LABEL_W-1:0] lb_lab, n_root, w_root, lab, gone;
    blob_act_e          act;

    assign start    = pix_valid && sof;
    assign col      = start ? '0 : col_q;
    assign row      = start ? '0 : row_q;
    assign free_cnt = start ? '0 : free_q;

    assign fg   = pix_valid && (pix_data >= threshold);
    assign n_fg = lb_fg && (row != '0);
    assign w_fg = wfg_q && (col != '0);
    assign hit  = (act != ACT_IDLE);

    blob_linebuf #(
        .COLS(COLS), .LABEL_W(LABEL_W), .COL_W(COL_W)
    ) u_line (
        .clk(clk), .rst(rst), .wr_en(pix_valid), .col(col),
        .wr_fg(hit), .wr_lab(lab), .rd_fg(lb_fg), .rd_lab(lb_lab)
    );

    blob_decide #(
        .NLABELS(NLABELS), .LABEL_W(LABEL_W), .CNT_W(CNT_W)
    ) u_decide (
        .fg(fg), .n_fg(n_fg), .n_root(n_root), .w_fg(w_fg), .w_root(w_root),
        .free_cnt(free_cnt), .act(act), .lab(lab), .gone(gone), .starve(starve)
    );

    blob_table #(
        .NLABELS(NLABELS), .LABEL_W(LABEL_W), .COL_W(COL_W), .ROW_W(ROW_W),
        .AREA_W(AREA_W), .SX_W(SX_W), .SY_W(SY_W)
    ) u_table (
        .clk(clk), .rst(rst), .clear(start), .act(act), .lab(lab), .gone(gone),
        .col(col), .row(row), .n_raw(lb_lab), .w_raw(wlab_q),
        .n_root(n_root), .w_root(w_root), .rd_label(rd_label),
        .rd_live(rd_live), .rd_area(rd_area), .rd_sumx(rd_sumx), .rd_sumy(rd_sumy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q  <= '0;
            row_q  <= '0;
            free_q <= '0;
            wfg_q  <= 1'b0;
            wlab_q <= '0;
            ovf_q  <= 1'b0;
            done_q <= 1'b0;
        end else if (pix_valid) begin
            if (eol) begin
                col_q <= '0;
                row_q <= row + ROW_W'(1);
            end else begin
                col_q <= col + COL_W'(1);
                row_q <= row;
            end
            free_q <= (act == ACT_FRESH) ? free_cnt + CNT_W'(1) : free_cnt;
            wfg_q  <= hit;
            wlab_q <= lab;
            ovf_q  <= (ovf_q && !sof) || starve;
            done_q <= eof || (done_q && !sof);
        end
    end

    assign label_overflow = ovf_q;
    assign frame_done     = done_q;

    // R8: the overflow flag holds until a new frame starts
    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !start) |=> ovf_q);

    // R2: the free-label counter never passes the table size
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        free_q <= CNT_W'(NLABELS));

    // R10: a new frame that does not also end drops the done flag
    a_r10_done_clear: assert property (@(posedge clk) disable iff (rst)
        (start && !eof) |=> !frame_done);

    // R8: a starved pixel leaves the line buffer marked background
    a_r8_starve_bg: assert property (@(posedge clk) disable iff (rst)
        starve |-> !hit);
endmodule

// File: tb/blob_labeler_tb.sv
`timescale 1ns/1ps
module blob_labeler_tb;
    localparam int DATA_W  = 8;
    localparam int COLS    = 16;
    localparam int ROWS    = 16;
    localparam int NLABELS = 16;
    localparam int LABEL_W = 4;
    localparam int AREA_W  = 9;
    localparam int SX_W    = 12;
    localparam int SY_W    = 12;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               pix_valid = 1'b0, sof = 1'b0, eol = 1'b0, eof = 1'b0;
    logic [DATA_W-1:0]  pix_data = '0, threshold = 8'd100;
    logic [LABEL_W-1:0] rd_label = '0;
    logic               rd_live, label_overflow, frame_done;
    logic [AREA_W-1:0]  rd_area;
    logic [SX_W-1:0]    rd_sumx;
    logic [SY_W-1:0]    rd_sumy;

    blob_labeler #(
        .DATA_W(DATA_W), .COLS(COLS), .ROWS(ROWS), .NLABELS(NLABELS)
    ) u_dut (
        .clk(clk), .rst(rst), .pix_valid(pix_valid), .sof(sof), .eol(eol), .eof(eof),
        .pix_data(pix_data), .threshold(threshold), .rd_label(rd_label),
        .rd_live(rd_live), .rd_area(rd_area), .rd_sumx(rd_sumx), .rd_sumy(rd_sumy),
        .label_overflow(label_overflow), .frame_done(frame_done)
    );

    always #2 clk = ~clk;

    int    vecs = 0, errs = 0;
    bit    finished = 0;
    string tag = "reset";

    // Behavioural model: union-find with parent pointers
    int m_par [NLABELS], m_live [NLABELS], m_area [NLABELS], m_sx [NLABELS], m_sy [NLABELS];
    int m_pfg [COLS], m_plab [COLS];
    int m_wfg = 0, m_wlab = 0, m_col = 0, m_row = 0, m_cnt = 0, m_ovf = 0, m_done = 0;
    int img [ROWS][COLS];

    function automatic int find(int x);
        int r = x;
        while (m_par[r] != r) r = m_par[r];
        return r;
    endfunction

    task automatic chk(string what, int got, int exp);
        vecs++;
        if (got != exp) begin
            errs++;
            $display("FAIL [%s] %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic compare_all();
        int l = int'(rd_label);
        chk("R8 overflow flag", int'(label_overflow), m_ovf);
        chk("R10 frame done", int'(frame_done), m_done);
        chk("R9 live", int'(rd_live), m_live[l]);
        if (m_live[l] != 0) begin
            chk("R9 area", int'(rd_area), m_area[l]);
            chk("R9 sumx", int'(rd_sumx), m_sx[l]);
            chk("R9 sumy", int'(rd_sumy), m_sy[l]);
        end
    endtask

    task automatic model_step(int data, int thr, bit s, bit e, bit f);
        int a = -1;
        int nf, wf, nr, wr, k, g;
        if (s) begin
            for (int i = 0; i < NLABELS; i++) begin
                m_live[i] = 0; m_area[i] = 0; m_sx[i] = 0; m_sy[i] = 0;
            end
            m_col = 0; m_row = 0; m_cnt = 0; m_ovf = 0;
        end
        nf = (m_row > 0 && m_pfg[m_col] != 0) ? 1 : 0;
        wf = (m_col > 0 && m_wfg != 0) ? 1 : 0;
        nr = find(m_plab[m_col]);
        wr = find(m_wlab);
        if (data >= thr) begin
            if (nf != 0 && wf != 0) begin
                if (nr == wr) a = nr;
                else begin
                    k = (nr < wr) ? nr : wr;
                    g = (nr < wr) ? wr : nr;
                    m_par[g] = k;
                    m_area[k] += m_area[g]; m_sx[k] += m_sx[g]; m_sy[k] += m_sy[g];
                    m_live[g] = 0; m_area[g] = 0; m_sx[g] = 0; m_sy[g] = 0;
                    a = k;
                end
            end else if (wf != 0) a = wr;
            else if (nf != 0) a = nr;
            else if (m_cnt == NLABELS) m_ovf = 1;
            else begin
                a = m_cnt; m_par[a] = a; m_live[a] = 1;
                m_area[a] = 0; m_sx[a] = 0; m_sy[a] = 0;
                m_cnt++;
            end
        end
        if (a >= 0) begin
            m_area[a] += 1; m_sx[a] += m_col; m_sy[a] += m_row;
        end
        m_pfg[m_col]  = (a >= 0) ? 1 : 0;
        m_plab[m_col] = (a >= 0) ? a : 0;
        m_wfg  = (a >= 0) ? 1 : 0;
        m_wlab = (a >= 0) ? a : 0;
        if (e) begin m_col = 0; m_row++; end else m_col++;
        if (f) m_done = 1; else if (s) m_done = 0;
    endtask

    task automatic tick(bit v, int data, bit s, bit e, bit f);
        @(negedge clk);
        compare_all();
        pix_valid = v; pix_data = data[DATA_W-1:0];
        sof = s; eol = e; eof = f;
        rd_label = rd_label + 1'b1;
        if (v) model_step(data, int'(threshold), s, e, f);
    endtask

    task automatic run_frame(int rows, int gap_pct);
        for (int r = 0; r < rows; r++) begin
            for (int c = 0; c < COLS; c++) begin
                while ($urandom_range(99) < gap_pct) tick(0, 0, 0, 0, 0);
                tick(1, img[r][c], (r == 0 && c == 0), (c == COLS - 1),
                     (r == rows - 1 && c == COLS - 1));
            end
        end
        for (int i = 0; i < NLABELS + 2; i++) tick(0, 0, 0, 0, 0);
    endtask

    task automatic probe(string req, int lab, int live, int area, int sx, int sy);
        @(negedge clk);
        compare_all();
        pix_valid = 0; sof = 0; eol = 0; eof = 0;
        rd_label = lab[LABEL_W-1:0];
        #1;
        tag = req;
        chk("live", int'(rd_live), live);
        if (live != 0) begin
            chk("area", int'(rd_area), area);
            chk("sumx", int'(rd_sumx), sx);
            chk("sumy", int'(rd_sumy), sy);
        end
    endtask

    task automatic blank(int bg);
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) img[r][c] = bg;
    endtask

    initial begin
        for (int i = 0; i < NLABELS; i++) begin
            m_par[i] = i; m_live[i] = 0; m_area[i] = 0; m_sx[i] = 0; m_sy[i] = 0;
        end
        for (int i = 0; i < COLS; i++) begin m_pfg[i] = 0; m_plab[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R10: reset state, nothing live and both flags low
        for (int l = 0; l < NLABELS; l++) probe("R10 reset", l, 0, 0, 0, 0);
        tag = "R10 reset flags";
        chk("R10 overflow low", int'(label_overflow), 0);
        chk("R10 done low", int'(frame_done), 0);

        // R1/R2/R5: 2x2 block, sub-threshold pixel beside it, a lone pixel apart
        threshold = 8'd100;
        blank(99);
        img[0][0] = 100; img[0][1] = 100; img[1][0] = 100; img[1][1] = 255;
        img[0][5] = 180;
        tag = "R5 block frame";
        run_frame(3, 0);
        probe("R5 block area, R1 edge threshold", 0, 1, 4, 2, 2);
        probe("R2 second fresh label", 1, 1, 1, 5, 0);
        probe("R2 no third label", 2, 0, 0, 0, 0);
        tag = "R10 done after frame";
        chk("R10 done high", int'(frame_done), 1);

        // R3/R4/R6/R7: U shape whose arms meet on the second line
        blank(0);
        img[0][1] = 200; img[0][3] = 200;
        img[1][1] = 200; img[1][2] = 200; img[1][3] = 200;
        tag = "R6 U frame";
        run_frame(2, 10);
        probe("R6 survivor R7 single count R3 R4 join", 0, 1, 5, 10, 3);
        probe("R6 absorbed label dead", 1, 0, 0, 0, 0);

        // R6: absorbed label still referenced from the line buffer
        blank(0);
        img[0][1] = 200; img[0][3] = 200;
        img[1][1] = 200; img[1][2] = 200; img[1][3] = 200;
        img[2][3] = 200; img[3][3] = 200;
        tag = "R6 stale north";
        run_frame(4, 0);
        probe("R6 stale reference resolves", 0, 1, 7, 16, 8);

        // R8: more isolated pixels than labels
        blank(0);
        for (int c = 0; c < COLS; c += 2) begin img[0][c] = 200; img[2][c] = 200; end
        img[4][0] = 200; img[5][0] = 200;
        tag = "R8 overflow frame";
        run_frame(6, 0);
        probe("R8 last label kept", 15, 1, 1, 14, 2);
        tag = "R8 overflow flag";
        chk("R8 overflow high", int'(label_overflow), 1);

        // R10: next frame start clears overflow and old statistics
        blank(0);
        img[1][4] = 200;
        tag = "R10 restart";
        run_frame(2, 0);
        tag = "R10 restart flags";
        chk("R10 overflow cleared", int'(label_overflow), 0);
        probe("R10 only new region", 0, 1, 1, 4, 1);
        probe("R10 old label gone", 15, 0, 0, 0, 0);

        // Random frames, compared every clock against the model
        for (int f = 0; f < 30; f++) begin
            int dens = $urandom_range(20, 80);
            threshold = DATA_W'(128);
            for (int r = 0; r < ROWS; r++)
                for (int c = 0; c < COLS; c++)
                    img[r][c] = ($urandom_range(99) < dens) ? $urandom_range(128, 255)
                                                             : $urandom_range(0, 127);
            tag = "random frame";
            run_frame($urandom_range(1, ROWS), 15);
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errs++;
            $display("FAIL [watchdog] run did not finish: got 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end
endmodule